// File: doc/BRIEF.md
# ATA Register and Multiword DMA Cycle Sequencer

This block runs the host side of a parallel ATA channel for two kinds of transfer. The first is a register transfer in programmed I/O, addressed to one byte register of the command block or of the control block. The second is a non-Ultra multiword DMA word transfer. A host starts a register transfer with a one-clock start pulse. The pulse carries the direction, the block select, a 3-bit register address and 16-bit write data. The host gets a one-clock done pulse when the transfer completes, and read data is valid at that pulse.

DMA runs need no start pulse. While DMA is enabled and the device raises its request, the sequencer selects the device through the active-low acknowledge and leaves the chip selects idle. It then moves one word per strobe. It keeps the acknowledge low from word to word for as long as the request stays high.

Both transfer kinds share one read strobe and one write strobe. Each transfer passes through a programmable setup time, a programmable strobe width and a programmable recovery time. The strobe is stretched while the device's ready line, after synchronization, stays low. The data bus is brought out as a separate input, output and output-enable.

Top module: `ataXferSeq`

## Requirements
- R1: While reset is low, both chip selects, both strobes and the DMA acknowledge are high (deasserted), the output enable is low, the device address is 0, done is low and read data is 0.
- R2: A register transfer drives exactly one chip select low: the command-block select when the block bit is 0, the control-block select when it is 1. The device address equals the requested address, and both are held from the first setup clock through one clock after the strobe deasserts. They are released during recovery.
- R3: The strobe asserts after the selection has been valid for setup+1 clocks.
- R4: The strobe stays low for at least pulse+1 clocks. It deasserts only on an edge where the ready input is high after passing two synchronizing flops, so ready is seen two clocks late. Read transfers use the read strobe and write transfers use the write strobe, and the two are never low together.
- R5: Read data is the input bus value sampled on the clock edge where the read strobe deasserts. It is presented on the read-data output and holds until the next read capture.
- R6: On a write, the output enable is high and the output bus carries the word from the first setup clock through the hold clock after the write strobe deasserts.
- R7: After the hold clock, recovery lasts recover+1 clocks with no strobe and no chip select. Done is then high for exactly one clock.
- R8: From idle, with DMA enabled and the request sampled high, a DMA word begins. The acknowledge is low, both chip selects are high, the device address is 0, and the direction comes from the DMA direction input (1 = to device).
- R9: At the end of each DMA word's recovery, the run continues with the next word if enable and request are both still high, and the acknowledge stays low. Otherwise the acknowledge goes high on the same edge and the sequencer returns to idle.
- R10: If a start pulse and a DMA request meet in the same idle clock, the register transfer goes first.
- R11: A start pulse that arrives while a transfer or DMA run is in progress is ignored, and no additional transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostStart | input | 1 | One-clock request for a register transfer |
| hostWrite | input | 1 | 1 = register write, 0 = register read |
| hostCtlBlk | input | 1 | 0 = command block, 1 = control block |
| hostAddr | input | 3 | Register address within the block |
| hostWdata | input | 16 | Write word (register write or DMA word to device) |
| dmaEnable | input | 1 | Allows DMA runs to start and continue |
| dmaToDevice | input | 1 | DMA direction, 1 = write to device |
| cfgSetup | input | 4 | Setup clocks minus one |
| cfgPulse | input | 4 | Minimum strobe clocks minus one |
| cfgRecover | input | 4 | Recovery clocks minus one |
| hostRdata | output | 16 | Last captured read word |
| hostDone | output | 1 | One-clock completion pulse per transfer |
| devCsCmdN | output | 1 | Active-low command-block chip select |
| devCsCtlN | output | 1 | Active-low control-block chip select |
| devAddr | output | 3 | Device register address |
| devRdN | output | 1 | Active-low read strobe |
| devWrN | output | 1 | Active-low write strobe |
| devAckN | output | 1 | Active-low DMA acknowledge |
| devDmaReq | input | 1 | DMA request from the device |
| devReady | input | 1 | Device ready, asynchronous |
| devDataIn | input | 16 | Data bus from device |
| devDataOut | output | 16 | Data bus to device |
| devDataOe | output | 1 | Data bus output enable |

## Verification
The bench stalls ready in the middle of a strobe. A design that used ready unsynchronized, or with the wrong delay, would release the strobe one or two clocks off. It changes the input bus every clock during DMA reads, so a capture taken one edge early or late shows up as a wrong word. It drops the request right after a word has started, which exposes a design that stops a run early or keeps the acknowledge after the last word. It also sends start pulses while the sequencer is busy and at the same moment as a DMA request. A sequencer that accepted the busy pulse would run an extra register transfer. One that let DMA win the tie would drive the acknowledge where a chip select belongs.

// File: rtl/ataSeqPkg.sv
package ataSeqPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_HOLD,
    PH_RECOV
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReg;   // latch a register request
    logic loadDma;   // latch first DMA word and direction
    logic loadWord;  // latch write data for a following DMA word
    logic capRead;   // sample input bus (strobe deasserting)
    logic selOn;     // selection/data phase (setup, active, hold)
    logic strobeOn;  // strobe asserted
    logic dmaRun;    // DMA run in progress
  } ctrlStrb_t;

endpackage

// File: rtl/ataSync.sv
module ataSync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= {STAGES{RST_VAL}};
    end else begin
      shReg[0] <= d;
      for (int i = 1; i < STAGES; i++) shReg[i] <= shReg[i-1];
    end
  end

  assign q = shReg[STAGES-1];

endmodule

// File: rtl/ataSeqCtrl.sv
module ataSeqCtrl
  import ataSeqPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostStart,
  input  logic             dmaEnable,
  input  logic             devDmaReq,
  input  logic             readySync,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgPulse,
  input  logic [CNT_W-1:0] cfgRecover,
  output ctrlStrb_t        strb,
  output logic             hostDone
);

  phase_e           phQ, phD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             runQ, runD;
  logic             doneQ, doneD;
  logic             cntZero;
  logic             dmaGo;
  logic             loadReg, loadDma, loadWord, capRead;

  assign cntZero = (cntQ == '0);
  assign dmaGo   = dmaEnable && devDmaReq;

  always_comb begin
    phD      = phQ;
    cntD     = cntQ;
    runD     = runQ;
    doneD    = 1'b0;
    loadReg  = 1'b0;
    loadDma  = 1'b0;
    loadWord = 1'b0;
    capRead  = 1'b0;
    unique case (phQ)
      PH_IDLE: begin
        if (hostStart) begin
          phD     = PH_SETUP;
          cntD    = cfgSetup;
          loadReg = 1'b1;
        end else if (dmaGo) begin
          phD     = PH_SETUP;
          cntD    = cfgSetup;
          loadDma = 1'b1;
          runD    = 1'b1;
        end
      end
      PH_SETUP: begin
        if (cntZero) begin
          phD  = PH_ACTIVE;
          cntD = cfgPulse;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (!cntZero) begin
          cntD = cntQ - 1'b1;
        end else if (readySync) begin
          phD     = PH_HOLD;
          capRead = 1'b1;
        end
      end
      PH_HOLD: begin
        phD  = PH_RECOV;
        cntD = cfgRecover;
      end
      PH_RECOV: begin
        if (!cntZero) begin
          cntD = cntQ - 1'b1;
        end else begin
          doneD = 1'b1;
          if (runQ && dmaGo) begin
            phD      = PH_SETUP;
            cntD     = cfgSetup;
            loadWord = 1'b1;
          end else begin
            phD  = PH_IDLE;
            runD = 1'b0;
          end
        end
      end
      default: begin
        phD  = PH_IDLE;
        runD = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phQ   <= PH_IDLE;
      cntQ  <= '0;
      runQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      phQ   <= phD;
      cntQ  <= cntD;
      runQ  <= runD;
      doneQ <= doneD;
    end
  end

  always_comb begin
    strb.loadReg  = loadReg;
    strb.loadDma  = loadDma;
    strb.loadWord = loadWord;
    strb.capRead  = capRead;
    strb.selOn    = (phQ == PH_SETUP) || (phQ == PH_ACTIVE) || (phQ == PH_HOLD);
    strb.strobeOn = (phQ == PH_ACTIVE);
    strb.dmaRun   = runQ;
  end

  assign hostDone = doneQ;

endmodule

// File: rtl/ataSeqDatapath.sv
module ataSeqDatapath
  import ataSeqPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              hostWrite,
  input  logic              hostCtlBlk,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              dmaToDevice,
  input  logic [DATA_W-1:0] devDataIn,
  output logic [DATA_W-1:0] hostRdata,
  output logic              devCsCmdN,
  output logic              devCsCtlN,
  output logic [ADDR_W-1:0] devAddr,
  output logic              devRdN,
  output logic              devWrN,
  output logic              devAckN,
  output logic [DATA_W-1:0] devDataOut,
  output logic              devDataOe
);

  logic              isWriteQ;
  logic              isCtlQ;
  logic              isDmaQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              regSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWriteQ <= 1'b0;
      isCtlQ   <= 1'b0;
      isDmaQ   <= 1'b0;
      addrQ    <= '0;
      wdataQ   <= '0;
      rdataQ   <= '0;
    end else begin
      if (strb.loadReg) begin
        isWriteQ <= hostWrite;
        isCtlQ   <= hostCtlBlk;
        isDmaQ   <= 1'b0;
        addrQ    <= hostAddr;
        wdataQ   <= hostWdata;
      end else if (strb.loadDma) begin
        isWriteQ <= dmaToDevice;
        isCtlQ   <= 1'b0;
        isDmaQ   <= 1'b1;
        addrQ    <= '0;
        wdataQ   <= hostWdata;
      end else if (strb.loadWord) begin
        wdataQ   <= hostWdata;
      end
      if (strb.capRead && !isWriteQ) rdataQ <= devDataIn;
    end
  end

  assign regSel     = strb.selOn && !isDmaQ;
  assign devCsCmdN  = !(regSel && !isCtlQ);
  assign devCsCtlN  = !(regSel && isCtlQ);
  assign devAddr    = regSel ? addrQ : '0;
  assign devRdN     = !(strb.strobeOn && !isWriteQ);
  assign devWrN     = !(strb.strobeOn && isWriteQ);
  assign devAckN    = !strb.dmaRun;
  assign devDataOe  = strb.selOn && isWriteQ;
  assign devDataOut = devDataOe ? wdataQ : '0;
  assign hostRdata  = rdataQ;

endmodule

// File: rtl/ataXferSeq.sv
module ataXferSeq
  import ataSeqPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStart,
  input  logic              hostWrite,
  input  logic              hostCtlBlk,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              dmaEnable,
  input  logic              dmaToDevice,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgPulse,
  input  logic [CNT_W-1:0]  cfgRecover,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostDone,
  output logic              devCsCmdN,
  output logic              devCsCtlN,
  output logic [ADDR_W-1:0] devAddr,
  output logic              devRdN,
  output logic              devWrN,
  output logic              devAckN,
  input  logic              devDmaReq,
  input  logic              devReady,
  input  logic [DATA_W-1:0] devDataIn,
  output logic [DATA_W-1:0] devDataOut,
  output logic              devDataOe
);

  ctrlStrb_t strb;
  logic      readySync;

  ataSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) rdySync_i (
    .clk (clk),
    .rstN(rstN),
    .d   (devReady),
    .q   (readySync)
  );

  ataSeqCtrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostStart (hostStart),
    .dmaEnable (dmaEnable),
    .devDmaReq (devDmaReq),
    .readySync (readySync),
    .cfgSetup  (cfgSetup),
    .cfgPulse  (cfgPulse),
    .cfgRecover(cfgRecover),
    .strb      (strb),
    .hostDone  (hostDone)
  );

  ataSeqDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostWrite  (hostWrite),
    .hostCtlBlk (hostCtlBlk),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .dmaToDevice(dmaToDevice),
    .devDataIn  (devDataIn),
    .hostRdata  (hostRdata),
    .devCsCmdN  (devCsCmdN),
    .devCsCtlN  (devCsCtlN),
    .devAddr    (devAddr),
    .devRdN     (devRdN),
    .devWrN     (devWrN),
    .devAckN    (devAckN),
    .devDataOut (devDataOut),
    .devDataOe  (devDataOe)
  );

endmodule

// File: rtl/ataXferSeqChk.sv
module ataXferSeqChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              devCsCmdN,
  input logic              devCsCtlN,
  input logic              devRdN,
  input logic              devWrN,
  input logic              devAckN,
  input logic [DATA_W-1:0] devDataOut,
  input logic              devDataOe,
  input logic              hostDone
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |-> (devCsCmdN && devCsCtlN && devRdN && devWrN && devAckN && !devDataOe && !hostDone));

  // R2
  one_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!devCsCmdN && !devCsCtlN));

  // R2
  strobe_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!devRdN || !devWrN) |-> (!devAckN || !devCsCmdN || !devCsCtlN));

  // R2
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(devRdN) || $rose(devWrN)) |-> (!devAckN || !devCsCmdN || !devCsCtlN));

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!devRdN && !devWrN));

  // R6
  oe_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devWrN |-> devDataOe);

  // R6
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!devWrN && $past(!devWrN)) |-> $stable(devDataOut));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  // R8
  ack_no_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devAckN |-> (devCsCmdN && devCsCtlN));

endmodule

bind ataXferSeq ataXferSeqChk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .devCsCmdN (devCsCmdN),
  .devCsCtlN (devCsCtlN),
  .devRdN    (devRdN),
  .devWrN    (devWrN),
  .devAckN   (devAckN),
  .devDataOut(devDataOut),
  .devDataOe (devDataOe),
  .hostDone  (hostDone)
);

// File: tb/ataXferSeq_tb_top.sv
module ataXferSeq_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostStart, hostWrite, hostCtlBlk;
  logic [2:0]  hostAddr;
  logic [15:0] hostWdata;
  logic        dmaEnable, dmaToDevice;
  logic [3:0]  cfgSetup, cfgPulse, cfgRecover;
  logic [15:0] hostRdata;
  logic        hostDone;
  logic        devCsCmdN, devCsCtlN;
  logic [2:0]  devAddr;
  logic        devRdN, devWrN, devAckN;
  logic        devDmaReq, devReady;
  logic [15:0] devDataIn;
  logic [15:0] devDataOut;
  logic        devDataOe;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;
  bit busInc = 1'b0;

  always #5 clk = ~clk;

  ataXferSeq dut_i (
    .clk(clk), .rstN(rstN),
    .hostStart(hostStart), .hostWrite(hostWrite), .hostCtlBlk(hostCtlBlk),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .dmaEnable(dmaEnable), .dmaToDevice(dmaToDevice),
    .cfgSetup(cfgSetup), .cfgPulse(cfgPulse), .cfgRecover(cfgRecover),
    .hostRdata(hostRdata), .hostDone(hostDone),
    .devCsCmdN(devCsCmdN), .devCsCtlN(devCsCtlN), .devAddr(devAddr),
    .devRdN(devRdN), .devWrN(devWrN), .devAckN(devAckN),
    .devDmaReq(devDmaReq), .devReady(devReady), .devDataIn(devDataIn),
    .devDataOut(devDataOut), .devDataOe(devDataOe)
  );

  // ---------------- behavioural reference model ----------------
  int          mPh;   // 0 idle, 1 setup, 2 strobe, 3 hold, 4 recovery
  int          mCnt;
  bit          mRun, mWr, mCtl, mDma, mDone, mR1, mR2, rdyUse;
  logic [2:0]  mAddr;
  logic [15:0] mWd, mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mRun = 0; mWr = 0; mCtl = 0; mDma = 0; mDone = 0;
      mAddr = '0; mWd = '0; mRd = '0; mR1 = 1; mR2 = 1;
    end else begin
      rdyUse = mR2;
      mR2 = mR1;
      mR1 = devReady;
      mDone = 0;
      case (mPh)
        0: if (hostStart) begin
             mPh = 1; mCnt = cfgSetup; mWr = hostWrite; mCtl = hostCtlBlk;
             mAddr = hostAddr; mWd = hostWdata; mDma = 0;
           end else if (dmaEnable && devDmaReq) begin
             mPh = 1; mCnt = cfgSetup; mWr = dmaToDevice; mDma = 1; mCtl = 0;
             mAddr = '0; mWd = hostWdata; mRun = 1;
           end
        1: if (mCnt == 0) begin mPh = 2; mCnt = cfgPulse; end else mCnt--;
        2: if (mCnt != 0) mCnt--;
           else if (rdyUse) begin mPh = 3; if (!mWr) mRd = devDataIn; end
        3: begin mPh = 4; mCnt = cfgRecover; end
        4: if (mCnt != 0) mCnt--;
           else begin
             mDone = 1;
             if (mRun && dmaEnable && devDmaReq) begin
               mPh = 1; mCnt = cfgSetup; mWd = hostWdata;
             end else begin
               mPh = 0; mRun = 0;
             end
           end
        default: mPh = 0;
      endcase
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit sel, rsel, oe;
    string t;
    sel  = (mPh >= 1) && (mPh <= 3);
    rsel = sel && !mDma;
    oe   = sel && mWr;
    t    = rstN ? "" : "R1 ";
    chk(devCsCmdN, !(rsel && !mCtl), {t, "R2"}, "csCmd");
    chk(devCsCtlN, !(rsel && mCtl), {t, "R2"}, "csCtl");
    chk(devAddr, rsel ? mAddr : 3'd0, {t, "R2"}, "addr");
    chk(devRdN, !(mPh == 2 && !mWr), {t, "R3 R4"}, "rdStrobe");
    chk(devWrN, !(mPh == 2 && mWr), {t, "R3 R4"}, "wrStrobe");
    chk(devDataOe, oe, {t, "R6"}, "oe");
    chk(devDataOut, oe ? mWd : 16'h0, {t, "R6"}, "dout");
    chk(devAckN, !mRun, {t, "R8 R9"}, "ack");
    chk(hostDone, mDone, {t, "R7"}, "done");
    chk(hostRdata, mRd, {t, "R5"}, "rdata");
  end

  always @(negedge clk) if (busInc) devDataIn <= devDataIn + 16'h0101;

  // ---------------- stimulus ----------------
  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic waitDone();
    int g = 0;
    do begin @(negedge clk); g++; end while (!hostDone && g < 500);
    if (!hostDone) begin checks++; errors++; $display("FAIL R7 done missing actual=0 expected=1"); end
  endtask

  task automatic waitAck();
    int g = 0;
    while (devAckN && g < 500) begin @(negedge clk); g++; end
  endtask

  task automatic regCycle(input bit wr, input bit ctl, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hostStart = 1; hostWrite = wr; hostCtlBlk = ctl; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostStart = 0;
    waitDone();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int n;
    rstN = 0; hostStart = 0; hostWrite = 0; hostCtlBlk = 0; hostAddr = 0; hostWdata = 0;
    dmaEnable = 0; dmaToDevice = 0; cfgSetup = 1; cfgPulse = 2; cfgRecover = 1;
    devDmaReq = 0; devReady = 1; devDataIn = 16'hA5A5;
    repeat (3) @(negedge clk);
    chk(devAckN, 1, "R1", "ack in reset");
    rstN = 1;

    // R2 R5: command-block read
    regCycle(0, 0, 3'd5, 16'h0);
    chk(hostRdata, 16'hA5A5, "R5", "read word");
    // R6: control-block write
    regCycle(1, 1, 3'd6, 16'h1234);

    // R4: ready held low stretches the strobe
    @(negedge clk);
    hostStart = 1; hostWrite = 0; hostCtlBlk = 1; hostAddr = 3'd2; devDataIn = 16'h3C3C;
    @(negedge clk);
    hostStart = 0; devReady = 0;
    repeat (8) @(negedge clk);
    devReady = 1;
    waitDone();
    chk(hostRdata, 16'h3C3C, "R4", "stalled read word");

    // minimum timing
    cfgSetup = 0; cfgPulse = 0; cfgRecover = 0;
    devDataIn = 16'h5A5A;
    regCycle(0, 1, 3'd7, 16'h0);
    regCycle(1, 0, 3'd1, 16'hC0DE);

    // R11: start pulse while busy is ignored
    cfgSetup = 2; cfgPulse = 3; cfgRecover = 2;
    @(negedge clk);
    hostStart = 1; hostWrite = 1; hostCtlBlk = 0; hostAddr = 3'd3; hostWdata = 16'h7777;
    @(negedge clk);
    hostStart = 0;
    repeat (2) @(negedge clk);
    hostStart = 1; hostWrite = 0; hostCtlBlk = 1; hostAddr = 3'd4;
    @(negedge clk);
    hostStart = 0;
    waitDone();
    repeat (3) @(negedge clk);
    chk({devCsCmdN, devCsCtlN}, 2'b11, "R11", "no extra cycle");

    // R8 R9: DMA read run of three words with a moving bus
    cfgSetup = 1; cfgPulse = 1; cfgRecover = 1;
    busInc = 1; dmaToDevice = 0; devDmaReq = 1;
    repeat (3) @(negedge clk);
    chk(devAckN, 1, "R8", "ack needs enable");
    dmaEnable = 1;
    waitAck();
    n = 0;
    for (int g = 0; g < 500 && !devAckN; g++) begin
      @(negedge clk);
      if (hostDone) begin n++; if (n == 2) devDmaReq = 0; end
    end
    chk(n, 3, "R9", "words in run");
    chk(devAckN, 1, "R9", "ack released");
    dmaEnable = 0; busInc = 0;

    // R9: single DMA write word
    dmaToDevice = 1; hostWdata = 16'hBEEF; dmaEnable = 1; devDmaReq = 1;
    waitAck();
    devDmaReq = 0;
    waitDone();
    chk(devAckN, 1, "R9", "ack after single word");
    dmaEnable = 0;

    // R10: register request wins over DMA request
    dmaToDevice = 0; dmaEnable = 1; devDmaReq = 1;
    hostStart = 1; hostWrite = 0; hostCtlBlk = 0; hostAddr = 3'd1;
    @(negedge clk);
    hostStart = 0;
    chk(devAckN, 1, "R10", "ack during register cycle");
    chk(devCsCmdN, 0, "R10", "register cycle first");
    waitDone();
    waitAck();
    devDmaReq = 0;
    waitDone();
    dmaEnable = 0;
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule